// File: doc/BRIEF.md
# Phase-Frequency Detector with Frequency Steering

This block compares a feedback signal against a reference derived from an oscillator and reports the sign and size of the error. The error is given as a three-level code plus a lock flag. Both the feedback pin and the oscillator pin are asynchronous. A fast system clock samples them through two-flop synchronizers and detects their edges internally. The reference is not a pin of its own. It is the terminal pulse of a small prescaler that counts oscillator rising edges and divides by the product of a four-or-five factor and a two/four/eight factor.

The detector is a ten-state machine. Feedback events step it toward the positive side and reference events step it toward the negative side. While the two rates are equal, the code is high or low only for the interval between the leading event and the lagging one, and rests at mid for the rest of the period. When one side keeps arriving twice before the other, the machine enters frequency-error states. There the code stays solidly high or low, and the lock flag drops, until the rate relationship reverses. A double-edge mode lets both edges of the feedback pin count, which doubles the effective feedback rate.

Top module: `pfd_steer`

## Requirements
- R1: While and after `rst`, `det_code` is mid (2'b00) and `lock_n` is 1, and the prescaler count restarts from zero.
- R2: `det_code` uses 2'b00 for mid, 2'b01 for low and 2'b10 for high, and never shows 2'b11.
- R3: From a locked mid state, a lone feedback event makes the code high while `lock_n` stays 1. A following reference event returns it to mid with `lock_n` still 1.
- R4: From a locked mid state, a lone reference event makes the code low while `lock_n` stays 1. A following feedback event returns it to mid with `lock_n` still 1.
- R5: A feedback event while the code is high moves the machine into positive frequency error. There the code stays high and `lock_n` is 0, under single reference events between feedback events as well. Only two reference events in a row leave it: the code then goes to mid with `lock_n` 0, and the next feedback event gives mid with `lock_n` 1.
- R6: A reference event while the code is low moves the machine into negative frequency error. There the code stays low and `lock_n` is 0, under single feedback events between reference events as well. Only two feedback events in a row leave it: the code then goes to mid with `lock_n` 0.
- R7: From the negative crossover (mid, `lock_n` 0), a feedback event gives high with `lock_n` 1, and a reference event gives mid with `lock_n` 1.
- R8: A feedback event and a reference event in the same system clock cycle cancel. The code and the lock flag hold.
- R9: With `dbl_off` = 0, a falling edge of `fb_in` counts as a feedback event just like a rising edge.
- R10: With `dbl_off` = 1, falling edges of `fb_in` have no effect on the code or the lock flag.
- R11: A reference event happens on every N-th rising edge of `osc_in`, and no output changes on the N-1 edges before it. N is the product of two factors. The first is 4 when `div45_sel` = 1 and 5 when it is 0. The second is 2, 4 or 8 when `div248_sel` is 2'b00, 2'b01 or 2'b10/2'b11 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_in | input | 1 | Oscillator signal feeding the prescaler (asynchronous) |
| fb_in | input | 1 | Feedback signal, the positive detector input (asynchronous) |
| dbl_off | input | 1 | 1: only rising feedback edges count; 0: both edges count |
| div45_sel | input | 1 | First prescaler factor: 1 selects 4, 0 selects 5 |
| div248_sel | input | 2 | Second prescaler factor: 00 selects 2, 01 selects 4, otherwise 8 |
| det_code | output | 2 | Detector level: 00 mid, 01 low, 10 high |
| lock_n | output | 1 | 1 in phase-only states, 0 in frequency-error or crossover states |

## Verification
The main function is driven by a sequence of single feedback and reference events. The sequence alternates events to check the phase-only states, repeats events on one side to force each frequency-error region, and then supplies two events in a row from the opposite side. The lock flag separates the solid-drive states from the transient phase pulses, which show the same code. A single feedback event after entering saturation tells a saturating machine from a plain up/down counter. Coincident events and falling feedback edges are applied under both settings of the double-edge control. The prescaler is clocked one edge short of its ratio and then onto it, for two different ratios.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  typedef enum logic [3:0] {
    ST_PHN_IDLE = 4'd1,
    ST_PHN_ACT  = 4'd2,
    ST_FRN_A    = 4'd3,
    ST_FRN_B    = 4'd4,
    ST_XN       = 4'd5,
    ST_PHP_IDLE = 4'd6,
    ST_PHP_ACT  = 4'd7,
    ST_FRP_A    = 4'd8,
    ST_FRP_B    = 4'd9,
    ST_XP       = 4'd10
  } pfd_state_t;

  typedef enum logic [1:0] {
    LVL_MID  = 2'b00,
    LVL_LOW  = 2'b01,
    LVL_HIGH = 2'b10
  } pfd_level_t;

  // up = 1: feedback event, up = 0: reference event
  function automatic pfd_state_t pfd_step(pfd_state_t s, logic up);
    pfd_state_t n;
    case (s)
      ST_PHN_IDLE: n = up ? ST_PHP_ACT  : ST_PHN_ACT;
      ST_PHP_IDLE: n = up ? ST_PHP_ACT  : ST_PHN_ACT;
      ST_PHP_ACT:  n = up ? ST_FRP_A    : ST_PHP_IDLE;
      ST_PHN_ACT:  n = up ? ST_PHN_IDLE : ST_FRN_A;
      ST_FRP_A:    n = up ? ST_FRP_A    : ST_FRP_B;
      ST_FRP_B:    n = up ? ST_FRP_A    : ST_XP;
      ST_XP:       n = up ? ST_PHP_IDLE : ST_PHN_ACT;
      ST_FRN_A:    n = up ? ST_FRN_B    : ST_FRN_A;
      ST_FRN_B:    n = up ? ST_XN       : ST_FRN_A;
      ST_XN:       n = up ? ST_PHP_ACT  : ST_PHN_IDLE;
      default:     n = ST_PHP_IDLE;
    endcase
    return n;
  endfunction

  function automatic pfd_level_t pfd_level(pfd_state_t s);
    pfd_level_t l;
    case (s)
      ST_PHP_ACT, ST_FRP_A, ST_FRP_B: l = LVL_HIGH;
      ST_PHN_ACT, ST_FRN_A, ST_FRN_B: l = LVL_LOW;
      default:                        l = LVL_MID;
    endcase
    return l;
  endfunction

  function automatic logic pfd_locked(pfd_state_t s);
    return (s == ST_PHN_IDLE) || (s == ST_PHN_ACT) ||
           (s == ST_PHP_IDLE) || (s == ST_PHP_ACT);
  endfunction

endpackage

// File: rtl/pfd_edge.sv
module pfd_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  input  logic both_en,
  output logic ev
);

  logic [SYNC_STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[SYNC_STAGES-1:0], d};
  end

  // sh[SYNC_STAGES-1] is the synchronized level, sh[SYNC_STAGES] its delay
  always_comb begin
    ev = (sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES]) |
         (both_en & ~sh[SYNC_STAGES-1] & sh[SYNC_STAGES]);
  end

endmodule

// File: rtl/pfd_refdiv.sv
module pfd_refdiv #(
  parameter int PRE_BASE = 4,
  parameter int POST_MIN = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       osc_ev,
  input  logic       div45_sel,
  input  logic [1:0] div248_sel,
  output logic       ref_ev
);

  localparam int MAX_RATIO = (PRE_BASE + 1) * (POST_MIN * 4);
  localparam int CW        = $clog2(MAX_RATIO + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;
  int            pre;
  int            post;

  always_comb begin
    pre = div45_sel ? PRE_BASE : PRE_BASE + 1;
    case (div248_sel)
      2'b00:   post = POST_MIN;
      2'b01:   post = POST_MIN * 2;
      default: post = POST_MIN * 4;
    endcase
    last = CW'(pre * post - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (osc_ev) begin
      if (cnt >= last) cnt <= '0;
      else             cnt <= cnt + 1'b1;
    end
  end

  assign ref_ev = osc_ev && (cnt >= last);

endmodule

// File: rtl/pfd_fsm.sv
module pfd_fsm
  import pfd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       fb_ev,
  input  logic       ref_ev,
  output logic [1:0] det_code,
  output logic       lock_n
);

  pfd_state_t state;
  pfd_state_t nxt;

  always_comb nxt = pfd_step(state, fb_ev);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_PHP_IDLE;
      det_code <= LVL_MID;
      lock_n   <= 1'b1;
    end else if (fb_ev ^ ref_ev) begin
      state    <= nxt;
      det_code <= pfd_level(nxt);
      lock_n   <= pfd_locked(nxt);
    end
  end

endmodule

// File: rtl/pfd_steer.sv
module pfd_steer #(
  parameter int SYNC_STAGES = 2,
  parameter int PRE_BASE    = 4,
  parameter int POST_MIN    = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       osc_in,
  input  logic       fb_in,
  input  logic       dbl_off,
  input  logic       div45_sel,
  input  logic [1:0] div248_sel,
  output logic [1:0] det_code,
  output logic       lock_n
);

  logic osc_ev;
  logic fb_ev;
  logic ref_ev;

  pfd_edge #(.SYNC_STAGES(SYNC_STAGES)) u_osc_edge (
    .clk(clk), .rst(rst), .d(osc_in), .both_en(1'b0), .ev(osc_ev)
  );

  pfd_edge #(.SYNC_STAGES(SYNC_STAGES)) u_fb_edge (
    .clk(clk), .rst(rst), .d(fb_in), .both_en(~dbl_off), .ev(fb_ev)
  );

  pfd_refdiv #(.PRE_BASE(PRE_BASE), .POST_MIN(POST_MIN)) u_div (
    .clk(clk), .rst(rst), .osc_ev(osc_ev), .div45_sel(div45_sel),
    .div248_sel(div248_sel), .ref_ev(ref_ev)
  );

  pfd_fsm u_fsm (
    .clk(clk), .rst(rst), .fb_ev(fb_ev), .ref_ev(ref_ev),
    .det_code(det_code), .lock_n(lock_n)
  );

endmodule

// File: rtl/pfd_steer_chk.sv
module pfd_steer_chk (
  input logic       clk,
  input logic       rst,
  input logic       fb_ev,
  input logic       ref_ev,
  input logic       osc_ev,
  input logic [1:0] det_code,
  input logic       lock_n
);

  a_r2_code_legal: assert property (@(posedge clk) disable iff (rst)
    det_code != 2'b11);

  a_r3_lead_high: assert property (@(posedge clk) disable iff (rst)
    (fb_ev && !ref_ev && lock_n && det_code == 2'b00)
      |=> (det_code == 2'b10 && lock_n));

  a_r3_lead_release: assert property (@(posedge clk) disable iff (rst)
    (ref_ev && !fb_ev && lock_n && det_code == 2'b10)
      |=> (det_code == 2'b00 && lock_n));

  a_r4_lag_low: assert property (@(posedge clk) disable iff (rst)
    (ref_ev && !fb_ev && lock_n && det_code == 2'b00)
      |=> (det_code == 2'b01 && lock_n));

  a_r5_pos_saturate: assert property (@(posedge clk) disable iff (rst)
    (fb_ev && !ref_ev && det_code == 2'b10)
      |=> (det_code == 2'b10 && !lock_n));

  a_r6_neg_saturate: assert property (@(posedge clk) disable iff (rst)
    (ref_ev && !fb_ev && det_code == 2'b01)
      |=> (det_code == 2'b01 && !lock_n));

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (fb_ev == ref_ev) |=> ($stable(det_code) && $stable(lock_n)));

  a_r11_ref_on_osc: assert property (@(posedge clk) disable iff (rst)
    ref_ev |-> osc_ev);

endmodule

bind pfd_steer pfd_steer_chk u_chk (
  .clk(clk), .rst(rst), .fb_ev(fb_ev), .ref_ev(ref_ev), .osc_ev(osc_ev),
  .det_code(det_code), .lock_n(lock_n)
);

// File: tb/sim_pfd_steer.sv
`timescale 1ns/1ps
module sim_pfd_steer;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       osc_in = 1'b0;
  logic       fb_in = 1'b0;
  logic       dbl_off = 1'b1;
  logic       div45_sel = 1'b1;
  logic [1:0] div248_sel = 2'b00;
  logic [1:0] det_code;
  logic       lock_n;

  int checks = 0;
  int errors = 0;
  int ratio = 8;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pfd_steer u0 (
    .clk(clk), .rst(rst), .osc_in(osc_in), .fb_in(fb_in), .dbl_off(dbl_off),
    .div45_sel(div45_sel), .div248_sel(div248_sel),
    .det_code(det_code), .lock_n(lock_n)
  );

  // {event (0 feedback, 1 reference), expected code, expected lock_n}
  localparam logic [3:0] VEC [0:25] = '{
    4'b0_10_1, 4'b1_00_1, 4'b1_01_1, 4'b0_00_1, 4'b0_10_1,
    4'b0_10_0, 4'b0_10_0, 4'b1_10_0, 4'b0_10_0, 4'b1_10_0,
    4'b1_00_0, 4'b0_00_1, 4'b1_01_1, 4'b1_01_0, 4'b1_01_0,
    4'b0_01_0, 4'b1_01_0, 4'b0_01_0, 4'b0_00_0, 4'b0_10_1,
    4'b1_00_1, 4'b1_01_1, 4'b1_01_0, 4'b0_01_0, 4'b0_00_0,
    4'b1_00_1
  };

  function automatic string vec_req(int i);
    if (i < 5)       return "R3/R4";
    else if (i < 12) return "R5";
    else if (i < 19) return "R6";
    else if (i < 22) return "R7";
    else             return "R6/R7";
  endfunction

  task automatic check(string req, logic [1:0] exp_code, logic exp_lock);
    checks++;
    if (det_code !== exp_code || lock_n !== exp_lock) begin
      errors++;
      $display("FAIL %s: code=%b lock_n=%b expected code=%b lock_n=%b",
               req, det_code, lock_n, exp_code, exp_lock);
    end
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    settle(4);
    rst = 1'b0;
    settle(2);
  endtask

  task automatic osc_pulse();
    osc_in = 1'b1; settle(3);
    osc_in = 1'b0; settle(3);
  endtask

  task automatic ref_event();
    repeat (ratio) osc_pulse();
  endtask

  task automatic fb_rise();
    fb_in = 1'b0; settle(6);
    fb_in = 1'b1; settle(6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: timeout");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    do_reset();
    check("R1", 2'b00, 1'b1);

    // table walk, single-edge mode, prescaler ratio 8 (R2 encodings)
    for (int i = 0; i < 26; i++) begin
      if (VEC[i][3]) ref_event();
      else           fb_rise();
      check(vec_req(i), VEC[i][2:1], VEC[i][0]);
    end

    // R1: reset from negative side, after activity
    fb_in = 1'b0;
    do_reset();
    check("R1", 2'b00, 1'b1);

    // R10: falling feedback edge ignored in single-edge mode
    dbl_off = 1'b1;
    fb_in = 1'b1; settle(6);
    check("R10", 2'b10, 1'b1);
    fb_in = 1'b0; settle(6);
    check("R10", 2'b10, 1'b1);

    // R9: double-edge mode, falling edge counts as a second event
    dbl_off = 1'b0;
    do_reset();
    fb_in = 1'b1; settle(6);
    check("R9", 2'b10, 1'b1);
    fb_in = 1'b0; settle(6);
    check("R9", 2'b10, 1'b0);
    dbl_off = 1'b1;

    // R11: ratio 5 x 8 = 40
    div45_sel = 1'b0; div248_sel = 2'b10; ratio = 40;
    do_reset();
    fb_rise();
    repeat (39) osc_pulse();
    check("R11", 2'b10, 1'b1);
    osc_pulse();
    check("R11", 2'b00, 1'b1);

    // R11: ratio 4 x 4 = 16
    div45_sel = 1'b1; div248_sel = 2'b01; ratio = 16;
    fb_in = 1'b0;
    do_reset();
    repeat (15) osc_pulse();
    check("R11", 2'b00, 1'b1);
    osc_pulse();
    check("R11", 2'b01, 1'b1);

    // R8: coincident feedback and reference events cancel
    div45_sel = 1'b1; div248_sel = 2'b00; ratio = 8;
    fb_in = 1'b0;
    do_reset();
    repeat (7) osc_pulse();
    fb_in = 1'b1; osc_in = 1'b1;
    settle(3);
    osc_in = 1'b0;
    settle(6);
    check("R8", 2'b00, 1'b1);
    fb_rise();
    check("R8", 2'b10, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule